// File: doc/BRIEF.md
# Serial Two-Wire Bus Control and Standby Supervisor

This block holds the 8-bit control word of a two-wire serial controller and watches the state of the link. It sits on a plain CPU register port with a write strobe, write data and combinational read data. It drives the enable for the shift/protocol engine and the per-line pull-low grants for the clock and data wires. It also drives three single-cycle outputs: a wait-cancel pulse, a flag-wipe pulse and a stop interrupt. From the engine it takes start, stop, address-match and extension-code indications. It also takes the engine's requests to pull each wire low.

Two command bits clear themselves. The "leave" command drops the block out of the current transfer into a standby state. In standby both wires are released, and the status flags and pending start/stop triggers are wiped. Standby ends on a stop condition, or on an address match or extension code that follows a start. The "wait-cancel" command releases a held wait. The stop interrupt is gated by its enable bit. Every command is dead while the master enable is off.

Top module: `i2c_ctrl_supervisor`

## Requirements
- R1: After reset the control word reads 0x00, the engine enable is 0, the status-preset output is 1, and every pulse output and pull-low grant is 0.
- R2: Bit layout, MSB to LSB: [7] enable, [6] leave, [5] wait-cancel, [4] stop-interrupt enable, [3] wait timing, [2] ack enable, [1] start trigger, [0] stop trigger. A write stores bits 7 and 4..0, which read back unchanged; `eng_enable` follows bit 7 and `status_preset` is its inverse.
- R3: A write with bits 7 and 6 both 1 makes bit 6 read 1 and raises `flag_clr` for exactly the one cycle after the write edge. Both are 0 from then on.
- R4: A write with bits 7 and 5 both 1 makes bit 5 read 1 and raises `wait_cancel` for exactly the one cycle after the write edge. Both are 0 from then on.
- R5: An accepted leave command forces the start and stop trigger bits (1 and 0) to 0, whatever that write carried for them.
- R6: From the edge that accepts a leave command until standby ends, `scl_pull_low` and `sda_pull_low` are 0 even while the engine requests a pull-low.
- R7: A rising stop indication during standby ends standby at that edge.
- R8: An address match or extension code ends standby only if a start was seen earlier in the same standby period; without one, standby holds.
- R9: A rising stop indication while bits 7 and 4 are 1 gives a one-cycle `stop_irq` in the cycle after the edge. A stop seen while bit 4 is 0 never causes a later interrupt.
- R10: While bit 7 is written 0, the leave and wait-cancel bits are ignored and read 0, no pulse or standby results, and stops raise no interrupt.
- R11: Writing bit 7 to 0 abandons standby, so re-enabling grants the pull-low requests at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control-word write strobe |
| reg_wdata | input | 8 | Control-word write data |
| reg_rdata | output | 8 | Control-word read data |
| eng_start_det | input | 1 | Start condition seen by the engine |
| eng_stop_det | input | 1 | Stop condition seen by the engine |
| eng_addr_match | input | 1 | Own address received |
| eng_ext_code | input | 1 | Extension code received |
| eng_scl_low_req | input | 1 | Engine wants the clock wire low |
| eng_sda_low_req | input | 1 | Engine wants the data wire low |
| eng_enable | output | 1 | Run enable to the engine |
| status_preset | output | 1 | Holds the status register at its reset value |
| flag_clr | output | 1 | One-cycle wipe of status flags on leave |
| wait_cancel | output | 1 | One-cycle wait release |
| stop_irq | output | 1 | One-cycle stop interrupt request |
| scl_pull_low | output | 1 | Granted clock-wire pull-low (0 floats the wire) |
| sda_pull_low | output | 1 | Granted data-wire pull-low (0 floats the wire) |

## Verification
A standby state that fails to set shows within one cycle of the leave write: a pull-low grant is 1 when it should be 0. A standby state that fails to end shows in the cycle after the stop or qualified match edge, when the grants stay at 0. A start memory that is wrong either frees the wires on an unqualified match or holds them after a qualified one, one cycle after that edge. A self-clear or gating fault in the control word shows on `reg_rdata` and the pulse outputs in the cycle after the write, or one cycle later if the bit fails to clear.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int CTRL_W = 8;
  localparam int B_EN   = 7;
  localparam int B_REL  = 6;
  localparam int B_WCAN = 5;
  localparam int B_SPIE = 4;
  localparam int B_WTIM = 3;
  localparam int B_ACKE = 2;
  localparam int B_STT  = 1;
  localparam int B_SPT  = 0;

  typedef struct packed {
    logic en;
    logic rel;
    logic wcan;
    logic spie;
    logic wtim;
    logic acke;
    logic stt;
    logic spt;
  } ctrl_t;

  typedef enum logic [1:0] {
    LNK_ACTIVE  = 2'd0,
    LNK_STANDBY = 2'd1,
    LNK_ARMED   = 2'd2
  } link_st_t;
endpackage

// File: rtl/i2cs_ctl_reg.sv
module i2cs_ctl_reg
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic              rel_req
);
  logic wr_en;
  logic wcan_req;

  assign wr_en    = wr & wdata[B_EN];
  assign rel_req  = wr_en & wdata[B_REL];
  assign wcan_req = wr_en & wdata[B_WCAN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      ctrl.rel  <= 1'b0;
      ctrl.wcan <= 1'b0;
      if (wr) begin
        ctrl.en   <= wdata[B_EN];
        ctrl.spie <= wdata[B_SPIE];
        ctrl.wtim <= wdata[B_WTIM];
        ctrl.acke <= wdata[B_ACKE];
        ctrl.rel  <= rel_req;
        ctrl.wcan <= wcan_req;
        if (rel_req) begin
          ctrl.stt <= 1'b0;
          ctrl.spt <= 1'b0;
        end else begin
          ctrl.stt <= wdata[B_STT];
          ctrl.spt <= wdata[B_SPT];
        end
      end
    end
  end
endmodule

// File: rtl/i2cs_standby_fsm.sv
module i2cs_standby_fsm
  import i2cs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rel_req,
  input  logic stop_rise,
  input  logic start_det,
  input  logic addr_match,
  input  logic ext_code,
  output logic standby
);
  link_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LNK_STANDBY: begin
        if (stop_rise)      st_d = LNK_ACTIVE;
        else if (start_det) st_d = LNK_ARMED;
      end
      LNK_ARMED: begin
        if (stop_rise || addr_match || ext_code) st_d = LNK_ACTIVE;
      end
      default: st_d = LNK_ACTIVE;
    endcase
    if (rel_req) st_d = LNK_STANDBY;
    if (!run && !rel_req) st_d = LNK_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= LNK_ACTIVE;
    else        st_q <= st_d;
  end

  assign standby = (st_q != LNK_ACTIVE);
endmodule

// File: rtl/i2cs_stop_irq.sv
module i2cs_stop_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_det,
  input  logic gate,
  output logic stop_rise,
  output logic irq
);
  logic stop_d;

  assign stop_rise = stop_det & ~stop_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_d <= 1'b0;
      irq    <= 1'b0;
    end else begin
      stop_d <= stop_det;
      irq    <= stop_rise & gate;
    end
  end
endmodule

// File: rtl/i2c_ctrl_supervisor.sv
module i2c_ctrl_supervisor
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              eng_start_det,
  input  logic              eng_stop_det,
  input  logic              eng_addr_match,
  input  logic              eng_ext_code,
  input  logic              eng_scl_low_req,
  input  logic              eng_sda_low_req,
  output logic              eng_enable,
  output logic              status_preset,
  output logic              flag_clr,
  output logic              wait_cancel,
  output logic              stop_irq,
  output logic              scl_pull_low,
  output logic              sda_pull_low
);
  ctrl_t ctrl;
  logic  rel_req;
  logic  stop_rise;
  logic  standby;
  logic  grant;

  i2cs_ctl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .ctrl    (ctrl),
    .rel_req (rel_req)
  );

  i2cs_stop_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_det  (eng_stop_det),
    .gate      (ctrl.en & ctrl.spie),
    .stop_rise (stop_rise),
    .irq       (stop_irq)
  );

  i2cs_standby_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (reg_wr ? reg_wdata[B_EN] : ctrl.en),
    .rel_req    (rel_req),
    .stop_rise  (stop_rise),
    .start_det  (eng_start_det),
    .addr_match (eng_addr_match),
    .ext_code   (eng_ext_code),
    .standby    (standby)
  );

  assign reg_rdata     = ctrl;
  assign eng_enable    = ctrl.en;
  assign status_preset = ~ctrl.en;
  assign flag_clr      = ctrl.rel;
  assign wait_cancel   = ctrl.wcan;
  assign grant         = ctrl.en & ~standby;
  assign scl_pull_low  = grant & eng_scl_low_req;
  assign sda_pull_low  = grant & eng_sda_low_req;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_rdata,
  input logic       eng_stop_det,
  input logic       eng_enable,
  input logic       flag_clr,
  input logic       wait_cancel,
  input logic       stop_irq,
  input logic       scl_pull_low,
  input logic       sda_pull_low
);
  a_r3_leave_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !flag_clr && !reg_rdata[6]);

  a_r4_wcan_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cancel |=> !wait_cancel && !reg_rdata[5]);

  a_r5_triggers_wiped: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |-> reg_rdata[1:0] == 2'b00);

  a_r6_lines_float: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |-> !scl_pull_low && !sda_pull_low);

  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |=> !stop_irq);

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |-> $past(eng_stop_det) && $past(eng_enable));

  a_r10_no_cmd_off: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_enable |-> !flag_clr && !wait_cancel && !scl_pull_low && !sda_pull_low);
endmodule

bind i2c_ctrl_supervisor i2cs_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_rdata    (reg_rdata),
  .eng_stop_det (eng_stop_det),
  .eng_enable   (eng_enable),
  .flag_clr     (flag_clr),
  .wait_cancel  (wait_cancel),
  .stop_irq     (stop_irq),
  .scl_pull_low (scl_pull_low),
  .sda_pull_low (sda_pull_low)
);

// File: tb/sim_i2c_ctrl_supervisor.sv
module sim_i2c_ctrl_supervisor;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic st = 1'b0, sp = 1'b0, am = 1'b0, ex = 1'b0;
  logic scl_req = 1'b1, sda_req = 1'b1;
  logic eng_enable, status_preset, flag_clr, wait_cancel, stop_irq, scl_pull_low, sda_pull_low;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string       q_tag[$];
  logic [15:0] q_exp[$];

  always #(PERIOD/2) clk = ~clk;

  i2c_ctrl_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_start_det(st), .eng_stop_det(sp), .eng_addr_match(am), .eng_ext_code(ex),
    .eng_scl_low_req(scl_req), .eng_sda_low_req(sda_req),
    .eng_enable(eng_enable), .status_preset(status_preset), .flag_clr(flag_clr),
    .wait_cancel(wait_cancel), .stop_irq(stop_irq),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low)
  );

  // Expected output vector: rdata, enable, flag_clr, wait_cancel, irq, preset, both pulls
  function automatic logic [15:0] mk(logic [7:0] rd, logic fc, logic wc, logic irq, logic pl);
    return {rd, rd[7], fc, wc, irq, ~rd[7], pl, pl, 1'b0};
  endfunction

  task automatic expect_now(string tag, logic [15:0] v);
    q_tag.push_back(tag);
    q_exp.push_back(v);
  endtask

  // Monitor: compares queued expectations shortly after each falling edge
  always @(negedge clk) begin
    #1;
    while (q_exp.size() > 0) begin
      string t;
      logic [15:0] e, a;
      t = q_tag.pop_front();
      e = q_exp.pop_front();
      a = {reg_rdata, eng_enable, flag_clr, wait_cancel, stop_irq, status_preset,
           scl_pull_low, sda_pull_low, 1'b0};
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic pulse_st(); st = 1'b1; step(); st = 1'b0; endtask
  task automatic pulse_sp(); sp = 1'b1; step(); sp = 1'b0; endtask
  task automatic pulse_am(); am = 1'b1; step(); am = 1'b0; endtask
  task automatic pulse_ex(); ex = 1'b1; step(); ex = 1'b0; endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    expect_now("R1 reset state", mk(8'h00, 0, 0, 0, 0));
    step();
    wr(8'h9F);
    expect_now("R2 stored bits readback", mk(8'h9F, 0, 0, 0, 1));
    step();
    // leave: trigger bits wiped, flag wipe pulse, wires float
    wr(8'hDF);
    expect_now("R3 R5 R6 leave issue cycle", mk(8'hDC, 1, 0, 0, 0));
    step();
    expect_now("R3 R6 leave self-cleared, standby holds", mk(8'h9C, 0, 0, 0, 0));
    pulse_am();
    expect_now("R8 match without start keeps standby", mk(8'h9C, 0, 0, 0, 0));
    pulse_st();
    expect_now("R8 start alone keeps standby", mk(8'h9C, 0, 0, 0, 0));
    pulse_am();
    expect_now("R8 match after start ends standby", mk(8'h9C, 0, 0, 0, 1));
    step();
    wr(8'hDC);
    expect_now("R3 second leave", mk(8'hDC, 1, 0, 0, 0));
    pulse_ex();
    expect_now("R8 ext code without start keeps standby", mk(8'h9C, 0, 0, 0, 0));
    pulse_st();
    pulse_ex();
    expect_now("R8 ext code after start ends standby", mk(8'h9C, 0, 0, 0, 1));
    wr(8'hDC);
    step();
    pulse_sp();
    expect_now("R7 R9 stop ends standby and interrupts", mk(8'h9C, 0, 0, 1, 1));
    step();
    expect_now("R9 interrupt lasts one cycle", mk(8'h9C, 0, 0, 0, 1));
    wr(8'hBC);
    expect_now("R4 wait cancel issue", mk(8'hBC, 0, 1, 0, 1));
    step();
    expect_now("R4 wait cancel self-cleared", mk(8'h9C, 0, 0, 0, 1));
    wr(8'h8C);
    pulse_sp();
    expect_now("R9 gated stop gives no interrupt", mk(8'h8C, 0, 0, 0, 1));
    wr(8'h9C);
    expect_now("R9 no late interrupt after regate", mk(8'h9C, 0, 0, 0, 1));
    step();
    expect_now("R9 still no late interrupt", mk(8'h9C, 0, 0, 0, 1));
    wr(8'h7C);
    expect_now("R10 commands ignored while disabled", mk(8'h1C, 0, 0, 0, 0));
    pulse_sp();
    expect_now("R10 no interrupt while disabled", mk(8'h1C, 0, 0, 0, 0));
    wr(8'h9C);
    expect_now("R10 no standby left by ignored leave", mk(8'h9C, 0, 0, 0, 1));
    wr(8'hDC);
    step();
    expect_now("R11 standby entered", mk(8'h9C, 0, 0, 0, 0));
    wr(8'h1C);
    wr(8'h9C);
    expect_now("R11 disable abandons standby", mk(8'h9C, 0, 0, 0, 1));
    step();
    step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule